// File: doc/BRIEF.md
# Interrupt and Address Control Register Write Masking

This block holds a small group of machine and supervisor control registers and applies per-register write masking. The registers are the interrupt-pending word, the interrupt-enable word (also reachable through a supervisor view), the supervisor page-table base and the supervisor trap vector. A control-register port carries an address, write data, a write strobe and an access strobe. Read data is presented combinationally for the selected address.

A narrow memory-mapped bus port is the only path that changes the machine software-interrupt pending bit. Each bus request returns a one-cycle response one clock later, with an accept flag. The port never applies back-pressure: a request is taken in the cycle its valid is high, and no ready signal exists.

Accesses to addresses outside the group raise an illegal flag one cycle later and change no state. The delegation word that drives the supervisor view comes in as a plain input. The pending and enable words are also driven out for downstream interrupt logic.

Top module: `csr_irq_wmask`

## Requirements
- R1: A write to the pending word (address 0x344) changes only bit 1 (supervisor software) and bit 5 (supervisor timer). Every other bit keeps its value, including bit 3.
- R2: A write to the enable word (address 0x304) stores only bits 1, 3, 5, 7, 9 and 12, so writing all ones reads back 0x12AA. All other bits read zero.
- R3: A write to the supervisor enable view (address 0x104) updates the enable word. Bits set in `irq_deleg` take the written value, and the other bits keep their value. The R2 mask still applies. Reading 0x104 returns the enable word ANDed with `irq_deleg`.
- R4: The page-table base (address 0x180) keeps only its low PA-12 bits, where PA is 50 when XLEN is 64 and 34 when XLEN is 32. This gives 38 or 22 bits. All higher bits read zero.
- R5: A write to the supervisor trap vector (address 0x105) stores the data with bits 1:0 cleared.
- R6: A bus write with valid at offset 0 sets pending bit 3 (machine software) to bit 0 of the written byte, at the same clock edge. One cycle later `bus_rsp_valid` is high with `bus_rsp_ok` high.
- R7: A bus write at any nonzero offset, and any bus read, is answered one cycle later with `bus_rsp_valid` high and `bus_rsp_ok` low. No state changes.
- R8: An access (`csr_en` high) to an address outside the five above raises `csr_illegal` for exactly one cycle, in the following cycle. No register changes.
- R9: After reset all registers read zero, `csr_illegal` is low and `bus_rsp_valid` is low.
- R10: `csr_rdata` follows `csr_addr` combinationally, and unknown addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_en | input | 1 | Register access strobe |
| csr_we | input | 1 | Write qualifier for the access |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data for csr_addr |
| csr_illegal | output | 1 | One-cycle flag for an access to an unknown address |
| irq_deleg | input | XLEN | Delegation mask for the supervisor enable view |
| bus_valid | input | 1 | Bus request valid; always accepted |
| bus_we | input | 1 | Bus request is a write |
| bus_off | input | BUS_OFF_W | Bus byte offset |
| bus_wbyte | input | 8 | Bus write byte |
| bus_rsp_valid | output | 1 | Response valid, one cycle after the request |
| bus_rsp_ok | output | 1 | Request accepted |
| irq_pending | output | XLEN | Pending word |
| irq_enable | output | XLEN | Enable word |

## Verification
The bench builds two copies of the block. One uses XLEN of 64, which covers the 38-bit page-table truncation and the upper half of the enable and vector words. The other uses XLEN of 32, where the truncation falls at 22 bits and the same masks must hold in a narrower word. The wide copy carries the scenarios for masking, delegation, the bus path and illegal addresses. The narrow copy confirms that the width-derived masks change with the parameter.

// File: rtl/csr_irq_pkg.sv
package csr_irq_pkg;
  localparam int BIT_SSIP = 1;
  localparam int BIT_MSIP = 3;
  localparam int BIT_STIP = 5;
  localparam int BIT_MTIP = 7;
  localparam int BIT_SEIP = 9;
  localparam int BIT_COP  = 12;
  localparam int PAGE_SHIFT = 12;

  localparam logic [11:0] ADR_SIE   = 12'h104;
  localparam logic [11:0] ADR_STVEC = 12'h105;
  localparam logic [11:0] ADR_SPTBR = 12'h180;
  localparam logic [11:0] ADR_MIE   = 12'h304;
  localparam logic [11:0] ADR_MIP   = 12'h344;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_PEND, SEL_EN, SEL_SEN, SEL_PTB, SEL_VEC
  } reg_sel_e;

  function automatic int phys_bits(input int xlen);
    return (xlen == 64) ? 50 : 34;
  endfunction
endpackage

// File: rtl/csr_irq_decode.sv
module csr_irq_decode
  import csr_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_en,
  input  logic        acc_we,
  input  logic [11:0] acc_addr,
  output reg_sel_e    sel,
  output logic        wr_go,
  output logic        illegal_q
);
  always_comb begin
    case (acc_addr)
      ADR_MIP:   sel = SEL_PEND;
      ADR_MIE:   sel = SEL_EN;
      ADR_SIE:   sel = SEL_SEN;
      ADR_SPTBR: sel = SEL_PTB;
      ADR_STVEC: sel = SEL_VEC;
      default:   sel = SEL_NONE;
    endcase
  end

  logic hit;
  assign hit   = (sel != SEL_NONE);
  assign wr_go = acc_en && acc_we && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= acc_en && !hit;
  end

  // R8: flag only follows an access to an unknown address
  p_illegal_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_q |-> $past(acc_en && (sel == SEL_NONE)));
endmodule

// File: rtl/csr_irq_regs.sv
module csr_irq_regs
  import csr_irq_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_go,
  input  reg_sel_e        sel,
  input  logic [XLEN-1:0] wdata,
  input  logic [XLEN-1:0] deleg,
  input  logic            sw_set_v,
  input  logic            sw_set_val,
  output logic [XLEN-1:0] pend_q,
  output logic [XLEN-1:0] en_q,
  output logic [XLEN-1:0] ptb_q,
  output logic [XLEN-1:0] vec_q
);
  localparam int PPN_W = phys_bits(XLEN) - PAGE_SHIFT;
  localparam logic [XLEN-1:0] PEND_WM = XLEN'((1 << BIT_SSIP) | (1 << BIT_STIP));
  localparam logic [XLEN-1:0] EN_WM   = XLEN'((1 << BIT_SSIP) | (1 << BIT_STIP) |
                                              (1 << BIT_SEIP) | (1 << BIT_COP)  |
                                              (1 << BIT_MSIP) | (1 << BIT_MTIP));
  localparam logic [XLEN-1:0] PPN_M   = {{(XLEN-PPN_W){1'b0}}, {PPN_W{1'b1}}};

  logic [XLEN-1:0] pend_n, en_n, ptb_n, vec_n, en_src;

  always_comb begin
    pend_n = pend_q;
    en_n   = en_q;
    ptb_n  = ptb_q;
    vec_n  = vec_q;
    en_src = (en_q & ~deleg) | (wdata & deleg);
    if (wr_go) begin
      case (sel)
        SEL_PEND: pend_n = (pend_q & ~PEND_WM) | (wdata & PEND_WM);
        SEL_EN:   en_n   = (en_q & ~EN_WM) | (wdata & EN_WM);
        SEL_SEN:  en_n   = (en_q & ~EN_WM) | (en_src & EN_WM);
        SEL_PTB:  ptb_n  = wdata & PPN_M;
        SEL_VEC:  vec_n  = {wdata[XLEN-1:2], 2'b00};
        default:  ;
      endcase
    end
    if (sw_set_v) pend_n[BIT_MSIP] = sw_set_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      ptb_q  <= '0;
      vec_q  <= '0;
    end else begin
      pend_q <= pend_n;
      en_q   <= en_n;
      ptb_q  <= ptb_n;
      vec_q  <= vec_n;
    end
  end

  p_pend_guard_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_set_v |=> ((pend_q & ~PEND_WM) == ($past(pend_q) & ~PEND_WM)));
  p_en_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~EN_WM) == '0);
  p_ptb_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptb_q & ~PPN_M) == '0);
  p_vec_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_q[1:0] == 2'b00);
  p_sw_bus_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_set_v |=> $stable(pend_q[BIT_MSIP]));
endmodule

// File: rtl/msip_bus_port.sv
module msip_bus_port #(
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_v,
  input  logic             req_we,
  input  logic [OFF_W-1:0] req_off,
  input  logic [7:0]       req_byte,
  output logic             set_v,
  output logic             set_val,
  output logic             rsp_v,
  output logic             rsp_ok
);
  assign set_v   = req_v && req_we && (req_off == '0);
  assign set_val = req_byte[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v  <= 1'b0;
      rsp_ok <= 1'b0;
    end else begin
      rsp_v  <= req_v;
      rsp_ok <= set_v;
    end
  end

  p_read_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_v && !req_we) |=> (rsp_v && !rsp_ok));
  p_rsp_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_v |-> $past(req_v));
endmodule

// File: rtl/csr_irq_wmask.sv
module csr_irq_wmask
  import csr_irq_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int BUS_OFF_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 csr_en,
  input  logic                 csr_we,
  input  logic [11:0]          csr_addr,
  input  logic [XLEN-1:0]      csr_wdata,
  output logic [XLEN-1:0]      csr_rdata,
  output logic                 csr_illegal,
  input  logic [XLEN-1:0]      irq_deleg,
  input  logic                 bus_valid,
  input  logic                 bus_we,
  input  logic [BUS_OFF_W-1:0] bus_off,
  input  logic [7:0]           bus_wbyte,
  output logic                 bus_rsp_valid,
  output logic                 bus_rsp_ok,
  output logic [XLEN-1:0]      irq_pending,
  output logic [XLEN-1:0]      irq_enable
);
  reg_sel_e        sel;
  logic            wr_go, sw_set_v, sw_set_val;
  logic [XLEN-1:0] pend_q, en_q, ptb_q, vec_q;

  csr_irq_decode u_dec (
    .clk(clk), .rst_n(rst_n), .acc_en(csr_en), .acc_we(csr_we),
    .acc_addr(csr_addr), .sel(sel), .wr_go(wr_go), .illegal_q(csr_illegal)
  );

  msip_bus_port #(.OFF_W(BUS_OFF_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .req_v(bus_valid), .req_we(bus_we),
    .req_off(bus_off), .req_byte(bus_wbyte), .set_v(sw_set_v),
    .set_val(sw_set_val), .rsp_v(bus_rsp_valid), .rsp_ok(bus_rsp_ok)
  );

  csr_irq_regs #(.XLEN(XLEN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .sel(sel), .wdata(csr_wdata),
    .deleg(irq_deleg), .sw_set_v(sw_set_v), .sw_set_val(sw_set_val),
    .pend_q(pend_q), .en_q(en_q), .ptb_q(ptb_q), .vec_q(vec_q)
  );

  always_comb begin
    case (sel)
      SEL_PEND: csr_rdata = pend_q;
      SEL_EN:   csr_rdata = en_q;
      SEL_SEN:  csr_rdata = en_q & irq_deleg;
      SEL_PTB:  csr_rdata = ptb_q;
      SEL_VEC:  csr_rdata = vec_q;
      default:  csr_rdata = '0;
    endcase
  end

  assign irq_pending = pend_q;
  assign irq_enable  = en_q;

  // R8: an illegal access leaves every register unchanged
  p_illegal_nochange_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && sel == SEL_NONE && !bus_valid) |=> ($stable(en_q) && $stable(ptb_q) &&
                                                   $stable(vec_q) && $stable(pend_q)));
endmodule

// File: tb/tb_csr_irq_wmask.sv
`timescale 1ns/1ps
module tb_csr_irq_wmask;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  logic        csr_en = 0, csr_we = 0;
  logic [11:0] csr_addr = '0;
  logic [63:0] csr_wdata = '0, csr_rdata, irq_deleg = '0, irq_pending, irq_enable;
  logic        csr_illegal;
  logic        bus_valid = 0, bus_we = 0;
  logic [3:0]  bus_off = '0;
  logic [7:0]  bus_wbyte = '0;
  logic        bus_rsp_valid, bus_rsp_ok;

  csr_irq_wmask #(.XLEN(64), .BUS_OFF_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
    .irq_deleg(irq_deleg), .bus_valid(bus_valid), .bus_we(bus_we), .bus_off(bus_off),
    .bus_wbyte(bus_wbyte), .bus_rsp_valid(bus_rsp_valid), .bus_rsp_ok(bus_rsp_ok),
    .irq_pending(irq_pending), .irq_enable(irq_enable)
  );

  logic        n_en = 0, n_we = 0;
  logic [11:0] n_addr = '0;
  logic [31:0] n_wdata = '0, n_rdata, n_pend, n_enab;
  logic        n_ill, n_rv, n_rok;

  csr_irq_wmask #(.XLEN(32), .BUS_OFF_W(4)) dut32 (
    .clk(clk), .rst_n(rst_n), .csr_en(n_en), .csr_we(n_we), .csr_addr(n_addr),
    .csr_wdata(n_wdata), .csr_rdata(n_rdata), .csr_illegal(n_ill),
    .irq_deleg(32'h0), .bus_valid(1'b0), .bus_we(1'b0), .bus_off(4'h0),
    .bus_wbyte(8'h00), .bus_rsp_valid(n_rv), .bus_rsp_ok(n_rok),
    .irq_pending(n_pend), .irq_enable(n_enab)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic csr_wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_en = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_en = 0; csr_we = 0;
  endtask

  task automatic csr_rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk);
    csr_addr = a;
    #1 d = csr_rdata;
  endtask

  task automatic bus_req(input logic we, input logic [3:0] off, input logic [7:0] b,
                         input string req, input logic exp_ok);
    @(negedge clk);
    bus_valid = 1; bus_we = we; bus_off = off; bus_wbyte = b;
    @(negedge clk);
    bus_valid = 0;
    check({req, " rsp_valid"}, 64'(bus_rsp_valid), 64'd1);
    check({req, " rsp_ok"}, 64'(bus_rsp_ok), 64'(exp_ok));
  endtask

  task automatic t_reset();
    logic [63:0] v;
    check("R9 illegal", 64'(csr_illegal), 64'd0);
    check("R9 rsp_valid", 64'(bus_rsp_valid), 64'd0);
    csr_rd(12'h344, v); check("R9 pend", v, 64'd0);
    csr_rd(12'h304, v); check("R9 en", v, 64'd0);
    csr_rd(12'h180, v); check("R9 ptb", v, 64'd0);
    csr_rd(12'h105, v); check("R9 vec", v, 64'd0);
  endtask

  task automatic t_pending();
    logic [63:0] v;
    csr_wr(12'h344, '1);
    csr_rd(12'h344, v); check("R1 pend all ones", v, 64'h22);
    bus_req(1'b1, 4'h0, 8'h01, "R6 set", 1'b1);
    csr_rd(12'h344, v); check("R6 msip set", v, 64'h2A);
    csr_wr(12'h344, 64'h0);
    csr_rd(12'h344, v); check("R1 msip kept", v, 64'h08);
    bus_req(1'b1, 4'h0, 8'hFE, "R6 clear", 1'b1);
    check("R6 msip cleared", irq_pending, 64'h0);
  endtask

  task automatic t_bus_reject();
    bus_req(1'b1, 4'h4, 8'h01, "R7 other offset", 1'b0);
    check("R7 pend unchanged", irq_pending, 64'h0);
    bus_req(1'b0, 4'h0, 8'h01, "R7 read", 1'b0);
    check("R7 pend after read", irq_pending, 64'h0);
  endtask

  task automatic t_enable();
    logic [63:0] v;
    csr_wr(12'h304, '1);
    csr_rd(12'h304, v); check("R2 en all ones", v, 64'h12AA);
    csr_wr(12'h304, 64'h0);
    csr_rd(12'h304, v); check("R2 en zero", v, 64'h0);
  endtask

  task automatic t_sie();
    logic [63:0] v;
    irq_deleg = 64'h8222;
    csr_wr(12'h304, '1);
    csr_wr(12'h104, 64'h0);
    csr_rd(12'h304, v); check("R3 undelegated kept", v, 64'h1088);
    csr_rd(12'h104, v); check("R3 sie view zero", v, 64'h0);
    csr_wr(12'h304, 64'h0);
    csr_wr(12'h104, '1);
    csr_rd(12'h304, v); check("R3 delegated set", v, 64'h0222);
    csr_rd(12'h104, v); check("R3 sie view", v, 64'h0222);
    irq_deleg = '0;
  endtask

  task automatic t_ptb_vec();
    logic [63:0] v;
    csr_wr(12'h180, '1);
    csr_rd(12'h180, v); check("R4 ptb 64", v, 64'h3F_FFFF_FFFF);
    csr_wr(12'h105, 64'h1237);
    csr_rd(12'h105, v); check("R5 vec", v, 64'h1234);
    csr_wr(12'h105, '1);
    csr_rd(12'h105, v); check("R5 vec ones", v, 64'hFFFF_FFFF_FFFF_FFFC);
    csr_rd(12'h7C0, v); check("R10 unknown reads zero", v, 64'h0);
  endtask

  task automatic t_illegal();
    logic [63:0] v;
    @(negedge clk);
    csr_en = 1; csr_we = 1; csr_addr = 12'h345; csr_wdata = '1;
    @(negedge clk);
    csr_en = 0; csr_we = 0;
    check("R8 flag raised", 64'(csr_illegal), 64'd1);
    @(negedge clk);
    check("R8 flag one cycle", 64'(csr_illegal), 64'd0);
    csr_rd(12'h344, v); check("R8 pend unchanged", v, 64'h0);
    csr_rd(12'h304, v); check("R8 en unchanged", v, 64'h0222);
  endtask

  task automatic t_narrow();
    @(negedge clk);
    n_en = 1; n_we = 1; n_addr = 12'h180; n_wdata = '1;
    @(negedge clk);
    n_addr = 12'h304;
    @(negedge clk);
    n_en = 0; n_we = 0; n_addr = 12'h180;
    #1 check("R4 ptb 32", 64'(n_rdata), 64'h3F_FFFF);
    check("R2 en 32", 64'(n_enab), 64'h12AA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_pending();
    t_bus_reject();
    t_enable();
    t_sie();
    t_ptb_vec();
    t_illegal();
    t_narrow();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule